// File: doc/BRIEF.md
# Register-Indirect Single-Word Transfer Engine

This block lets a local processor make one 32-bit access on a remote bus by programming registers instead of driving the bus itself. Software loads a target address and, for a store, a data word. It then writes a command word that carries a start flag together with a direction. The engine runs a single request/acknowledge transaction on its master port. A busy flag in the command register stays set until the transaction ends, and software polls that flag rather than waiting for an interrupt. A load returns its data in the value register.

Control is a two-state machine. `ST_IDLE` leaves the master port quiet and accepts register writes. In `ST_WAIT`, `m_req` is held and a cycle counter runs. The machine has three transitions. `T_ACCEPT` (`ST_IDLE` to `ST_WAIT`) is taken on a well-formed start command. `T_ACK` (`ST_WAIT` to `ST_IDLE`) is taken when the remote side acknowledges. `T_EXPIRE` (`ST_WAIT` to `ST_IDLE`) is taken when the acknowledge has not arrived within `TIMEOUT_CYC` cycles. A malformed start command, or an expired wait, sets a sticky error flag.

The register file has four words, selected by `cfg_idx`:
- index 0: command
- index 1: address
- index 2: value
- index 3: a fixed identification word

A write happens in any cycle where `cfg_sel` and `cfg_wr` are both high. `cfg_rdata` shows the selected word combinationally.

Top module: `regdma_engine`

## Requirements
- R1: After reset the engine is idle. `m_req` is 0, and the command, address and value words all read 0.
- R2: A transfer starts only from a command write in which bit 31 (start) is 1 and exactly one of bit 0 (read) or bit 1 (write) is 1. `m_req` rises on the cycle after the write. A command of 0x800000F2 starts a write: `m_we` is 1, `m_addr` carries the address word and `m_wdata` carries the value word.
- R3: Bit 12 (busy) of the command word reads 1 from the accepting edge until the edge that samples `m_ack` high. It reads 0 right after that edge.
- R4: On a read transfer, `m_rdata` sampled with `m_ack` is stored in the value word by the same edge that clears busy.
- R5: A command write with bit 31 set and bits 1:0 equal to 00 or 11 starts no transfer and sets bit 16 (error). A command write with bit 31 clear starts nothing and leaves the error flag unchanged. Every command write accepted while idle stores bits 7:4 (auxiliary field).
- R6: The error flag is sticky. Only the acceptance of a well-formed start command clears it.
- R7: While busy, writes to the command, address and value words are ignored. The auxiliary field, address and value keep their contents, and the running transfer's direction, address and data do not change.
- R8: If `m_ack` is not seen within `TIMEOUT_CYC` cycles of `m_req` being high, `m_req` drops, busy clears and the error flag sets.
- R9: A read of the command word shows only the auxiliary field (bits 7:4), busy (bit 12) and error (bit 16). All other bits, including start, read and write, read 0.
- R10: Index 3 always reads 0x00000FFF, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 for a register write |
| cfg_idx | input | 2 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| m_req | output | 1 | Remote transaction request |
| m_we | output | 1 | Remote direction, 1 for a write |
| m_addr | output | 32 | Remote target address |
| m_wdata | output | 32 | Remote write data |
| m_rdata | input | 32 | Remote read data |
| m_ack | input | 1 | Remote acknowledge |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a live transfer. The bench holds back its acknowledge while `m_req` is high. During that window it writes a new address and a conflicting start command. Only then does it release the acknowledge, and it checks that the read that actually ran used the original address and direction. The timeout edge is reached by never acknowledging, with the limit lowered to 16 so that busy can be sampled in the last waiting cycle and again in the first idle cycle.

// File: rtl/regdma_pkg.sv
package regdma_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned IDX_W    = 2;

    localparam logic [IDX_W-1:0] IDX_CMD   = 2'd0;
    localparam logic [IDX_W-1:0] IDX_ADDR  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_VALUE = 2'd2;
    localparam logic [IDX_W-1:0] IDX_IDENT = 2'd3;

    localparam int unsigned BIT_RD    = 0;
    localparam int unsigned BIT_WR    = 1;
    localparam int unsigned AUX_LO    = 4;
    localparam int unsigned AUX_W     = 4;
    localparam int unsigned BIT_BUSY  = 12;
    localparam int unsigned BIT_ERR   = 16;
    localparam int unsigned BIT_START = 31;

    localparam logic [WORD_W-1:0] IDENT_WORD = 32'h0000_0FFF;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic             go_rd;
        logic             go_wr;
        logic             bad;
        logic [AUX_W-1:0] aux;
    } cmd_dec_t;

endpackage

// File: rtl/regdma_cmd_decode.sv
module regdma_cmd_decode
    import regdma_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output cmd_dec_t          dec
);
    logic start;
    logic rd;
    logic wr;
    logic unused_bits;

    assign start = cmd_word[BIT_START];
    assign rd    = cmd_word[BIT_RD];
    assign wr    = cmd_word[BIT_WR];

    always_comb begin
        dec.go_rd = start & rd & ~wr;
        dec.go_wr = start & wr & ~rd;
        dec.bad   = start & ~(rd ^ wr);
        dec.aux   = cmd_word[AUX_LO +: AUX_W];
    end

    assign unused_bits = ^{cmd_word[30:8], cmd_word[3:2]};

endmodule

// File: rtl/regdma_xfer_fsm.sv
module regdma_xfer_fsm
    import regdma_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic m_ack,
    output logic busy,
    output logic m_req,
    output logic done_ok,
    output logic done_expire
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    xfer_state_e state_q, state_d;
    logic [CNT_W-1:0] wait_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // wait counter, restarted on every acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          wait_cnt <= '0;
        else if (state_q == ST_IDLE)         wait_cnt <= '0;
        else if (!m_ack && wait_cnt != CNT_LAST) wait_cnt <= wait_cnt + 1'b1;
    end

    // next state: T_ACCEPT, T_ACK, T_EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_WAIT;
            ST_WAIT: if (m_ack || wait_cnt == CNT_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        m_req       = 1'b0;
        done_ok     = 1'b0;
        done_expire = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                busy        = 1'b1;
                m_req       = 1'b1;
                done_ok     = m_ack;
                done_expire = ~m_ack & (wait_cnt == CNT_LAST);
            end
            default: ;
        endcase
    end

    // R8: counter never passes the limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < CNT_W'(TIMEOUT_CYC));

    // R8: an expired wait releases the request on the next cycle
    p_expire_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack && wait_cnt == CNT_LAST) |=> !m_req);

    // R3: acknowledge ends the request
    p_ack_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> !busy);

endmodule

// File: rtl/regdma_engine.sv
module regdma_engine
    import regdma_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata,
    input  logic        m_ack
);
    cmd_dec_t          dec;
    logic              busy;
    logic              done_ok;
    logic              done_expire;
    logic              wr_cmd, wr_addr, wr_val;
    logic              launch;
    logic [AUX_W-1:0]  aux_q;
    logic              err_q;
    logic              we_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] value_q;

    regdma_cmd_decode u_dec (
        .cmd_word (cfg_wdata),
        .dec      (dec)
    );

    assign wr_cmd  = cfg_sel & cfg_wr & (cfg_idx == IDX_CMD)   & ~busy;
    assign wr_addr = cfg_sel & cfg_wr & (cfg_idx == IDX_ADDR)  & ~busy;
    assign wr_val  = cfg_sel & cfg_wr & (cfg_idx == IDX_VALUE) & ~busy;
    assign launch  = wr_cmd & (dec.go_rd | dec.go_wr);

    regdma_xfer_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .m_ack       (m_ack),
        .busy        (busy),
        .m_req       (m_req),
        .done_ok     (done_ok),
        .done_expire (done_expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q   <= '0;
            err_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            value_q <= '0;
        end else begin
            if (wr_cmd) aux_q <= dec.aux;
            if (launch) begin
                we_q  <= dec.go_wr;
                err_q <= 1'b0;
            end else if ((wr_cmd && dec.bad) || done_expire) begin
                err_q <= 1'b1;
            end
            if (wr_addr) addr_q <= cfg_wdata;
            if (wr_val)
                value_q <= cfg_wdata;
            else if (done_ok && !we_q)
                value_q <= m_rdata;
        end
    end

    assign m_we    = we_q;
    assign m_addr  = addr_q;
    assign m_wdata = value_q;

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_idx)
            IDX_CMD: begin
                cfg_rdata[AUX_LO +: AUX_W] = aux_q;
                cfg_rdata[BIT_BUSY]        = busy;
                cfg_rdata[BIT_ERR]         = err_q;
            end
            IDX_ADDR:  cfg_rdata = addr_q;
            IDX_VALUE: cfg_rdata = value_q;
            IDX_IDENT: cfg_rdata = IDENT_WORD;
            default:   cfg_rdata = '0;
        endcase
    end

    // R2: a request only begins after a well-formed start command
    p_launch_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_req) |-> $past(cfg_sel && cfg_wr && cfg_idx == IDX_CMD
                               && cfg_wdata[BIT_START]
                               && (cfg_wdata[BIT_RD] != cfg_wdata[BIT_WR])));

    // R7: transfer attributes hold for the whole request
    p_attr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && $past(m_req)) |-> ($stable(m_addr) && $stable(m_wdata) && $stable(m_we)));

    // R4: read data captured at the acknowledge
    p_read_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack && !m_we) |=> (value_q == $past(m_rdata)));

    // R5: a malformed start flags an error and stays idle
    p_bad_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && cfg_sel && cfg_wr && cfg_idx == IDX_CMD && cfg_wdata[BIT_START]
         && (cfg_wdata[BIT_RD] == cfg_wdata[BIT_WR])) |=> (err_q && !m_req));

endmodule

// File: tb/tb_regdma_engine.sv
module tb_regdma_engine;
    logic        clk;
    logic        rst_n;
    logic        cfg_sel;
    logic        cfg_wr;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        m_req;
    logic        m_we;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata;
    logic        m_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam int unsigned TMO = 16;

    regdma_engine #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1; cfg_wr = 1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 0; cfg_wr = 0;
    endtask

    task automatic rreg(input logic [1:0] idx, output logic [31:0] d);
        cfg_idx = idx;
        #1;
        d = cfg_rdata;
    endtask

    // acknowledge the pending request after dly extra cycles
    task automatic serve(input int dly, input logic [31:0] rd);
        logic [31:0] v;
        while (!m_req) @(negedge clk);
        repeat (dly) @(negedge clk);
        rreg(2'd0, v);
        chk("R3 busy before ack", {31'd0, v[12]}, 32'd1);
        m_ack = 1; m_rdata = rd;
        @(negedge clk);
        m_ack = 0; m_rdata = 32'hDEAD_0000;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rreg(2'd0, v); chk("R1 command word", v, 32'd0);
        rreg(2'd1, v); chk("R1 address word", v, 32'd0);
        rreg(2'd2, v); chk("R1 value word", v, 32'd0);
        chk("R1 m_req", {31'd0, m_req}, 32'd0);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        wreg(2'd3, 32'h1234_5678);
        rreg(2'd3, v); chk("R10 identification word", v, 32'h0000_0FFF);
        chk("R10 no request", {31'd0, m_req}, 32'd0);
    endtask

    task automatic t_write;
        logic [31:0] v;
        wreg(2'd1, 32'h0040_1100);
        wreg(2'd2, 32'hCAFE_F00D);
        wreg(2'd0, 32'h8000_00F2);
        chk("R2 m_req after start", {31'd0, m_req}, 32'd1);
        chk("R2 direction write", {31'd0, m_we}, 32'd1);
        chk("R2 address", m_addr, 32'h0040_1100);
        chk("R2 data", m_wdata, 32'hCAFE_F00D);
        rreg(2'd0, v);
        chk("R9 command readback while busy", v, 32'h0000_10F0);
        serve(3, 32'h0);
        rreg(2'd0, v);
        chk("R3 busy clear after ack", v, 32'h0000_00F0);
        rreg(2'd2, v); chk("R2 value kept after write", v, 32'hCAFE_F00D);
    endtask

    task automatic t_read;
        logic [31:0] v;
        wreg(2'd1, 32'h0000_0A00);
        wreg(2'd0, 32'h8000_0011);
        chk("R2 direction read", {31'd0, m_we}, 32'd0);
        serve(0, 32'h5A5A_A5A5);
        rreg(2'd0, v); chk("R3 busy clear after read", v, 32'h0000_0010);
        rreg(2'd2, v); chk("R4 read data latched", v, 32'h5A5A_A5A5);
    endtask

    task automatic t_bad;
        logic [31:0] v;
        wreg(2'd0, 32'h8000_0003);
        chk("R5 both bits no request", {31'd0, m_req}, 32'd0);
        rreg(2'd0, v); chk("R5 both bits error", v, 32'h0001_0000);
        wreg(2'd0, 32'h0000_0071);
        chk("R5 no start no request", {31'd0, m_req}, 32'd0);
        rreg(2'd0, v); chk("R6 error sticky, aux stored", v, 32'h0001_0070);
        wreg(2'd0, 32'h8000_0030);
        chk("R5 neither bit no request", {31'd0, m_req}, 32'd0);
        rreg(2'd0, v); chk("R5 neither bit error", v, 32'h0001_0030);
        wreg(2'd0, 32'h8000_0001);
        rreg(2'd0, v); chk("R6 error cleared on accept", v, 32'h0000_1000);
        serve(1, 32'h1);
    endtask

    task automatic t_busy_writes;
        logic [31:0] v;
        wreg(2'd1, 32'h0000_0B00);
        wreg(2'd0, 32'h8000_00A1);
        wreg(2'd1, 32'h0000_0C00);
        wreg(2'd2, 32'h7777_7777);
        wreg(2'd0, 32'h8000_0052);
        chk("R7 direction unchanged", {31'd0, m_we}, 32'd0);
        chk("R7 address unchanged", m_addr, 32'h0000_0B00);
        rreg(2'd0, v); chk("R7 aux unchanged", v, 32'h0000_10A0);
        serve(2, 32'h3C3C_0101);
        rreg(2'd1, v); chk("R7 address word kept", v, 32'h0000_0B00);
        rreg(2'd2, v); chk("R7 read result not overwritten", v, 32'h3C3C_0101);
        @(negedge clk);
        chk("R7 no second transfer", {31'd0, m_req}, 32'd0);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        wreg(2'd0, 32'h8000_0002);
        repeat (TMO - 1) @(negedge clk);
        rreg(2'd0, v); chk("R8 busy in last wait cycle", v, 32'h0000_1000);
        @(negedge clk);
        rreg(2'd0, v); chk("R8 expired: idle with error", v, 32'h0001_0000);
        chk("R8 request dropped", {31'd0, m_req}, 32'd0);
    endtask

    initial begin
        rst_n = 0; cfg_sel = 0; cfg_wr = 0; cfg_idx = 0; cfg_wdata = 0;
        m_ack = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ident();
        t_write();
        t_read();
        t_bad();
        t_busy_writes();
        t_timeout();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule